// File: doc/BRIEF.md
# Configurable Memory-Map Chip-Select Decoder

This block turns a 24-bit bus address into exactly one device select. It holds three 8-bit control registers on the same bus, and their bits steer several address windows between the possible targets. Among the targets are the internal and on-board SRAMs, expansion RAM, flash, cartridge ROM, expansion ROM, internal mask ROM, user expansion space and three fixed I/O windows. When a window's enabling condition is false, only the `cs_none` flag is raised. External logic can then claim that range.

The select decode is purely combinational from the address, the write flag, the active-low cartridge input and the current register contents. A register write takes effect at the next rising clock edge. A register read returns its contents on `bus_rdata` in the same cycle.

Two windows give different targets for reads and writes. When both the ROM-enable and RAM-enable bits are set, reads from these windows go to ROM and writes go to on-board SRAM. This lets software copy ROM contents into the RAM that lies underneath them.

Top module: `memmap_cs_decoder`

## Requirements
- R1: In every cycle exactly one of the eleven `cs_sel` bits or `cs_none` is 1. The `cs_sel` bit positions are: 0 internal SRAM, 1 on-board SRAM, 2 expansion RAM, 3 flash, 4 cartridge ROM, 5 expansion ROM, 6 mask ROM, 7 expansion space, 8 video I/O, 9 peripheral I/O, 10 clock-port I/O.
- R2: The three registers are: routing at 0x00DF27, window control at 0x00DF40 and timing control at 0x00DF41.
  - When `bus_valid` and `bus_wr` are both 1 and the address matches a register, that register loads `bus_wdata` at the next rising edge. A write with `bus_valid` at 0 changes nothing.
  - While the address matches a register, `reg_hit` is 1 and `bus_rdata` shows that register. Otherwise both are 0.
- R3: A synchronous active-high `rst` clears all three registers to 0.
- R4: In 0x000000–0x0001FF the select is on-board SRAM when timing bit 2 is 1, and internal SRAM when it is 0.
- R5: In 0x000200–0x007FFF the select is on-board SRAM when routing bit 5 is 1 and routing bit 3 is 0. Otherwise the result is none.
- R6: In 0x008000–0x00DEFF, when routing bit 4 is 1, the select is flash if `cart_n` is 1 and cartridge ROM if `cart_n` is 0. When routing bit 4 is 0 the result is none.
- R7: The following windows select a fixed target regardless of register contents:
  - 0x00DF00–0x00DF1F selects video I/O.
  - 0x00DF20–0x00DFBF selects peripheral I/O.
  - 0x00DFC0–0x00DFFF selects clock-port I/O.
- R8: In 0x00E000–0x00FFFF:
  - When window bit 7 is 0, the select is mask ROM.
  - When window bit 7 is 1, the select is flash if routing bit 4 is 1.
  - Otherwise it is on-board SRAM if routing bit 5 is 1.
  - Otherwise the result is none.
- R9: When routing bit 5 is 1, 0x010000–0x19FFFF selects on-board SRAM and 0x200000–0x3FFFFF selects expansion RAM. When that bit is 0, both windows give none. 0x1A0000–0x1FFFFF always gives none.
- R10: 0x400000–0xBFFFFF selects expansion space when routing bit 6 is 1. When routing bit 7 is 1, 0xC00000–0xC7FFFF selects flash and 0xC80000–0xFFFFFF selects expansion ROM. When the controlling bit is 0, each of these windows gives none.
- R11: In the R6 and R8 windows, when routing bits 4 and 5 are both 1 (and, for R8, window bit 7 is 1), an access with `bus_wr` = 1 selects on-board SRAM. Reads keep the ROM target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access in progress |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Bus address |
| bus_wdata | input | 8 | Write data for control registers |
| cart_n | input | 1 | Cartridge present, active low |
| bus_rdata | output | 8 | Control register read data |
| reg_hit | output | 1 | Address matches a control register |
| cs_sel | output | 11 | One-hot device selects |
| cs_none | output | 1 | No device claims the address |

## Verification
The hardest case to reach is the read/write split. It needs routing bits 4 and 5 both set, the window bit set for the upper window, and a write aimed at a ROM window. The bench reaches it by programming each routing pattern through real bus writes to the three registers. Under every pattern it then sweeps both edges of every window with reads and writes, with the cartridge input both high and low. A behavioural model tracks the register contents from the same bus traffic, and every cycle is compared against it.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 8;
    localparam int N_TGT    = 11;
    localparam int N_REGION = 13;
    localparam int N_REGS   = 3;

    typedef enum logic [3:0] {
        RG_ZP, RG_LOW, RG_ROMWIN, RG_VIDEO, RG_PERIPH, RG_CLKPORT,
        RG_TOPWIN, RG_RAMHI, RG_GAP, RG_EXPRAM, RG_EXPSPC, RG_FLASHHI, RG_EXPROM
    } region_e;

    localparam logic [ADDR_W-1:0] REGION_BASE [N_REGION] = '{
        24'h000000, 24'h000200, 24'h008000, 24'h00DF00, 24'h00DF20,
        24'h00DFC0, 24'h00E000, 24'h010000, 24'h1A0000, 24'h200000,
        24'h400000, 24'hC00000, 24'hC80000
    };

    localparam int T_INT_SRAM = 0;
    localparam int T_OB_SRAM  = 1;
    localparam int T_EXP_RAM  = 2;
    localparam int T_FLASH    = 3;
    localparam int T_CART_ROM = 4;
    localparam int T_EXP_ROM  = 5;
    localparam int T_MASK_ROM = 6;
    localparam int T_EXP_SPC  = 7;
    localparam int T_VIDEO    = 8;
    localparam int T_PERIPH   = 9;
    localparam int T_CLKPORT  = 10;

    localparam int RT_LOW_OFF = 3;
    localparam int RT_ROM_EN  = 4;
    localparam int RT_RAM_EN  = 5;
    localparam int RT_EXPSPC  = 6;
    localparam int RT_HI_EN   = 7;
    localparam int WN_TOP_EN  = 7;
    localparam int TM_ZP_EXT  = 2;

    localparam logic [ADDR_W-1:0] REG_ADDR [N_REGS] = '{24'h00DF27, 24'h00DF40, 24'h00DF41};

    typedef struct packed {
        logic [DATA_W-1:0] route;
        logic [DATA_W-1:0] window;
        logic [DATA_W-1:0] timing;
    } ctrl_t;

    function automatic logic [N_TGT-1:0] tgt_onehot(input int t);
        logic [N_TGT-1:0] v;
        v = '0;
        v[t] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/memmap_ctrl_regs.sv
module memmap_ctrl_regs
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              hit
);
    logic [DATA_W-1:0] regs [N_REGS];
    logic [N_REGS-1:0] match;

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        assign match[g] = (bus_addr == REG_ADDR[g]);
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (bus_valid && bus_wr && match[g])
                regs[g] <= bus_wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REGS; i++)
            if (match[i]) rdata = regs[i];
    end

    assign hit  = |match;
    assign ctrl = '{route: regs[0], window: regs[1], timing: regs[2]};

    // R3: registers come out of reset cleared
    a_r3_reset_clear: assert property (@(posedge clk) rst |=> (ctrl == '0));
    // R2: a valid write to the routing register is visible next cycle
    a_r2_route_write: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_wr && bus_addr == REG_ADDR[0]) |=> (ctrl.route == $past(bus_wdata)));
    // R2: without a valid write the registers hold
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_wr) |=> $stable(ctrl));
endmodule

// File: rtl/memmap_region_lookup.sv
module memmap_region_lookup
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        region = RG_ZP;
        for (int i = 0; i < N_REGION; i++)
            if (addr >= REGION_BASE[i]) region = region_e'(i[3:0]);
    end
endmodule

// File: rtl/memmap_target_select.sv
module memmap_target_select
    import memmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  region_e          region,
    input  ctrl_t            ctrl,
    input  logic             wr,
    input  logic             cart_n,
    output logic [N_TGT-1:0] sel,
    output logic             none
);
    logic rom_en, ram_en, both_en;
    assign rom_en  = ctrl.route[RT_ROM_EN];
    assign ram_en  = ctrl.route[RT_RAM_EN];
    assign both_en = rom_en && ram_en;

    always_comb begin
        sel = '0;
        unique case (region)
            RG_ZP:      sel = ctrl.timing[TM_ZP_EXT] ? tgt_onehot(T_OB_SRAM) : tgt_onehot(T_INT_SRAM);
            RG_LOW:     if (ram_en && !ctrl.route[RT_LOW_OFF]) sel = tgt_onehot(T_OB_SRAM);
            RG_ROMWIN: begin
                if (both_en && wr)  sel = tgt_onehot(T_OB_SRAM);
                else if (rom_en)    sel = cart_n ? tgt_onehot(T_FLASH) : tgt_onehot(T_CART_ROM);
            end
            RG_VIDEO:   sel = tgt_onehot(T_VIDEO);
            RG_PERIPH:  sel = tgt_onehot(T_PERIPH);
            RG_CLKPORT: sel = tgt_onehot(T_CLKPORT);
            RG_TOPWIN: begin
                if (!ctrl.window[WN_TOP_EN]) sel = tgt_onehot(T_MASK_ROM);
                else if (both_en && wr)      sel = tgt_onehot(T_OB_SRAM);
                else if (rom_en)             sel = tgt_onehot(T_FLASH);
                else if (ram_en)             sel = tgt_onehot(T_OB_SRAM);
            end
            RG_RAMHI:   if (ram_en) sel = tgt_onehot(T_OB_SRAM);
            RG_GAP:     sel = '0;
            RG_EXPRAM:  if (ram_en) sel = tgt_onehot(T_EXP_RAM);
            RG_EXPSPC:  if (ctrl.route[RT_EXPSPC]) sel = tgt_onehot(T_EXP_SPC);
            RG_FLASHHI: if (ctrl.route[RT_HI_EN]) sel = tgt_onehot(T_FLASH);
            RG_EXPROM:  if (ctrl.route[RT_HI_EN]) sel = tgt_onehot(T_EXP_ROM);
            default:    sel = '0;
        endcase
    end

    assign none = (sel == '0);

    // R7: fixed I/O windows never depend on configuration
    a_r7_video_fixed: assert property (@(posedge clk) disable iff (rst)
        (region == RG_VIDEO) |-> sel[T_VIDEO]);
    // R11: writes into the ROM window with both enables land in SRAM
    a_r11_split_write: assert property (@(posedge clk) disable iff (rst)
        (region == RG_ROMWIN && both_en && wr) |-> sel[T_OB_SRAM]);
    // R9: the hole above the SRAM window is never claimed
    a_r9_gap_none: assert property (@(posedge clk) disable iff (rst)
        (region == RG_GAP) |-> none);
endmodule

// File: rtl/memmap_cs_decoder.sv
module memmap_cs_decoder
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              cart_n,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reg_hit,
    output logic [N_TGT-1:0]  cs_sel,
    output logic              cs_none
);
    ctrl_t   ctrl;
    region_e region;

    memmap_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ctrl(ctrl), .rdata(bus_rdata), .hit(reg_hit)
    );

    memmap_region_lookup u_lookup (.addr(bus_addr), .region(region));

    memmap_target_select u_select (
        .clk(clk), .rst(rst), .region(region), .ctrl(ctrl), .wr(bus_wr),
        .cart_n(cart_n), .sel(cs_sel), .none(cs_none)
    );

    // R1: exactly one claimant for every address
    a_r1_one_claim: assert property (@(posedge clk) disable iff (rst)
        $onehot({cs_sel, cs_none}));
    // R4: after reset the zero-page window points at internal SRAM
    a_r4_boot_zp: assert property (@(posedge clk)
        ($past(rst) && bus_addr < 24'h000200) |-> cs_sel[T_INT_SRAM]);
endmodule

// File: tb/memmap_cs_decoder_bench.sv
module memmap_cs_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_wr = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        cart_n = 1'b1;
    logic [7:0]  bus_rdata;
    logic        reg_hit;
    logic [10:0] cs_sel;
    logic        cs_none;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int m_route = 0, m_window = 0, m_timing = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memmap_cs_decoder u_memmap_cs_decoder (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cart_n(cart_n),
        .bus_rdata(bus_rdata), .reg_hit(reg_hit), .cs_sel(cs_sel), .cs_none(cs_none)
    );

    function automatic bit b(input int v, input int k);
        return ((v >> k) & 1) != 0;
    endfunction

    // returns target index, -1 for none; tag names the requirement
    function automatic int model(input int a, input bit wr, input bit cart, output string tag);
        bit rom = b(m_route, 4), ram = b(m_route, 5);
        if (a < 'h200)      begin tag = "R4";  return b(m_timing, 2) ? 1 : 0; end
        if (a < 'h8000)     begin tag = "R5";  return (ram && !b(m_route, 3)) ? 1 : -1; end
        if (a < 'hDF00) begin
            tag = (rom && ram && wr) ? "R11" : "R6";
            if (rom && ram && wr) return 1;
            if (rom) return cart ? 3 : 4;
            return -1;
        end
        if (a < 'hDF20)     begin tag = "R7";  return 8; end
        if (a < 'hDFC0)     begin tag = "R7";  return 9; end
        if (a < 'hE000)     begin tag = "R7";  return 10; end
        if (a < 'h10000) begin
            tag = "R8";
            if (!b(m_window, 7)) return 6;
            if (rom && ram && wr) begin tag = "R11"; return 1; end
            if (rom) return 3;
            if (ram) return 1;
            return -1;
        end
        if (a < 'h1A0000)   begin tag = "R9";  return ram ? 1 : -1; end
        if (a < 'h200000)   begin tag = "R9";  return -1; end
        if (a < 'h400000)   begin tag = "R9";  return ram ? 2 : -1; end
        if (a < 'hC00000)   begin tag = "R10"; return b(m_route, 6) ? 7 : -1; end
        if (a < 'hC80000)   begin tag = "R10"; return b(m_route, 7) ? 3 : -1; end
        tag = "R10";
        return b(m_route, 7) ? 5 : -1;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(input bit v, input bit w, input int a, input int d, input bit c);
        string tag;
        int t, exp_rd;
        bit exp_hit;
        logic [11:0] exp_vec;
        @(negedge clk);
        bus_valid = v; bus_wr = w; bus_addr = a[23:0]; bus_wdata = d[7:0]; cart_n = c;
        #1;
        t = model(a, w, c, tag);
        exp_vec = (t < 0) ? 12'h800 : (12'h1 << t);
        check({cs_none, cs_sel} == exp_vec, tag, "select", {cs_none, cs_sel}, exp_vec);
        check({cs_none, cs_sel} != 0 && $onehot({cs_none, cs_sel}), "R1", "one claim", {cs_none, cs_sel}, exp_vec);
        exp_hit = (a == 'hDF27) || (a == 'hDF40) || (a == 'hDF41);
        exp_rd  = (a == 'hDF27) ? m_route : (a == 'hDF40) ? m_window : (a == 'hDF41) ? m_timing : 0;
        check(reg_hit == exp_hit && bus_rdata == exp_rd[7:0], "R2", "readback", {reg_hit, bus_rdata}, {exp_hit, exp_rd[7:0]});
        @(posedge clk);
        if (v && w) begin
            if (a == 'hDF27) m_route  = d & 'hFF;
            if (a == 'hDF40) m_window = d & 'hFF;
            if (a == 'hDF41) m_timing = d & 'hFF;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int bounds [26] = '{'h0, 'h1FF, 'h200, 'h7FFF, 'h8000, 'hDEFF, 'hDF00, 'hDF1F, 'hDF20,
                            'hDFBF, 'hDFC0, 'hDFFF, 'hE000, 'hFFFF, 'h10000, 'h19FFFF,
                            'h1A0000, 'h1FFFFF, 'h200000, 'h3FFFFF, 'h400000, 'hBFFFFF,
                            'hC00000, 'hC7FFFF, 'hC80000, 'hFFFFFF};
        int routes [9] = '{'h00, 'h20, 'h28, 'h10, 'h30, 'hB0, 'hF8, 'h40, 'h80};
        repeat (3) @(posedge clk);
        // load junk during reset; R3 requires it to be discarded
        @(negedge clk); bus_valid = 1; bus_wr = 1; bus_addr = 24'h00DF27; bus_wdata = 8'hFF;
        @(posedge clk);
        @(negedge clk); rst = 0; bus_valid = 0; bus_wr = 0;
        // R3: reset state seen through readback and boot targets
        cycle(0, 0, 'hDF27, 0, 1);
        cycle(0, 0, 'hDF40, 0, 1);
        cycle(0, 0, 'hDF41, 0, 1);
        cycle(0, 0, 'h000010, 0, 1);
        cycle(0, 0, 'h00FFFC, 0, 1);
        // R2: write without valid is ignored, then a real write lands
        cycle(0, 1, 'hDF27, 'hAA, 1);
        cycle(0, 0, 'hDF27, 0, 1);
        cycle(1, 1, 'hDF27, 'h5A, 1);
        cycle(0, 0, 'hDF27, 0, 1);
        for (int r = 0; r < 9; r++)
            for (int wn = 0; wn < 2; wn++)
                for (int tm = 0; tm < 2; tm++) begin
                    cycle(1, 1, 'hDF27, routes[r], 1);
                    cycle(1, 1, 'hDF40, wn * 'h80, 1);
                    cycle(1, 1, 'hDF41, tm * 'h04, 1);
                    for (int c = 0; c < 2; c++)
                        for (int w = 0; w < 2; w++)
                            for (int k = 0; k < 26; k++)
                                cycle(1, w[0], bounds[k], 0, c[0]);
                end
        // R3: reset mid-run clears everything again
        @(negedge clk); rst = 1; bus_valid = 0; bus_wr = 0;
        @(posedge clk);
        @(negedge clk); rst = 0;
        m_route = 0; m_window = 0; m_timing = 0;
        cycle(0, 0, 'hDF27, 0, 1);
        cycle(0, 0, 'h00E100, 0, 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule